// File: doc/BRIEF.md
# Signed Nibble Seven-Segment Decoder

This block turns a 4-bit two's complement code into what two seven-segment digits need in order to show its signed decimal value. The left digit carries only the sign: its middle bar lights when the value is negative, and it stays dark otherwise. The right digit shows the absolute value, from 0 to 8.

The decoder is purely combinational and has no clock, no reset and no storage. A change on the input code shows up on both segment buses in the same cycle, so the block can sit directly between a register or a switch bank and the display drivers.

Internally the code is converted to sign-magnitude form. The magnitude path is a full four bits wide, because the most negative code, 1000, has a magnitude of 8. That magnitude cannot be written as a positive 4-bit two's complement number, and it must still appear on the display as an 8.

Top module: `snib_seg_display`

## Requirements
- R1: Both segment buses are active-high. Bit 0 drives segment a (top), bit 1 drives b (upper right), bit 2 drives c (lower right), bit 3 drives d (bottom), bit 4 drives e (lower left), bit 5 drives f (upper left) and bit 6 drives g (middle).
- R2: `code_i` is read as two's complement, with bit 3 as the sign bit. Codes 0000 to 0111 stand for 0 to +7, and codes 1000 to 1111 stand for -8 to -1.
- R3: Sign digit bit 6 (segment g) is 1 exactly when `code_i[3]` is 1.
- R4: Sign digit bits 5 to 0 (segments a to f) are 0 for all 16 codes.
- R5: For codes 0001 to 0111, the magnitude digit shows the code's own value. The patterns on `mag_seg_o[6:0]` are: 1 = 0000110, 2 = 1011011, 3 = 1001111, 4 = 1100110, 5 = 1101101, 6 = 1111101, 7 = 0000111. For example, code 0011 gives a blank sign digit and a 3.
- R6: For codes 1001 to 1111, the magnitude digit shows the negated value, which is the bitwise inverse of the code plus one. For example, code 1111 shows the sign bar and a 1.
- R7: Code 1000 shows the sign bar and the digit 8, which is `mag_seg_o` = 1111111.
- R8: Code 0000 shows a blank sign digit and the digit 0, which is `mag_seg_o` = 0111111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 4 | Two's complement value to display, bit 3 is the sign |
| sign_seg_o | output | 7 | Segment lines of the sign digit, bit 0 = a through bit 6 = g |
| mag_seg_o | output | 7 | Segment lines of the magnitude digit, bit 0 = a through bit 6 = g |

## Verification
The bench builds the block with its default parameter values. These fix the input at four bits and the segment buses at seven lines. With only sixteen input codes, every code can be driven: the zero code, each positive value, each negative value, and the lone code 1000, whose magnitude overflows the positive range. For each code, the bench compares both digits against patterns it builds per segment from the digit shapes in the requirements.

// File: rtl/snib_pkg.sv
package snib_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned MAG_W  = NIB_W;
  localparam int unsigned SEG_N  = 7;

  typedef logic [SEG_N-1:0] seg_t;
  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [MAG_W-1:0] mag_t;

  typedef enum int unsigned {
    SEG_A = 0, SEG_B = 1, SEG_C = 2, SEG_D = 3,
    SEG_E = 4, SEG_F = 5, SEG_G = 6
  } seg_idx_e;

  localparam seg_t SEG_OFF = '0;

  // Shape of a decimal digit 0..8, bit 0 = a .. bit 6 = g; blank above 8
  function automatic seg_t digit_shape(input mag_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      default: s = SEG_OFF;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/snib_magnitude.sv
module snib_magnitude
  import snib_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic [W-1:0] code_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  localparam int unsigned SIGN_BIT = W - 1;

  logic [W-1:0] inv_plus_one;

  assign neg_o        = code_i[SIGN_BIT];
  // Width W, not W-1: the most negative code needs its top bit
  assign inv_plus_one = (~code_i) + W'(1);
  assign mag_o        = neg_o ? inv_plus_one : code_i;
endmodule

// File: rtl/snib_digit_glyph.sv
module snib_digit_glyph
  import snib_pkg::*;
(
  input  mag_t mag_i,
  output seg_t seg_o
);
  assign seg_o = digit_shape(mag_i);
endmodule

// File: rtl/snib_sign_glyph.sv
module snib_sign_glyph
  import snib_pkg::*;
#(
  parameter int unsigned N = SEG_N
) (
  input  logic         neg_i,
  output logic [N-1:0] seg_o
);
  localparam int unsigned BAR = SEG_G;

  for (genvar i = 0; i < N; i++) begin : g_seg
    if (i == BAR) begin : g_bar
      assign seg_o[i] = neg_i;
    end else begin : g_dark
      assign seg_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/snib_seg_display.sv
module snib_seg_display
  import snib_pkg::*;
(
  input  logic [3:0] code_i,
  output logic [6:0] sign_seg_o,
  output logic [6:0] mag_seg_o
);
  logic neg;
  mag_t mag;

  snib_magnitude #(.W(NIB_W)) u_mag (
    .code_i (code_i),
    .neg_o  (neg),
    .mag_o  (mag)
  );

  snib_sign_glyph #(.N(SEG_N)) u_sign (
    .neg_i (neg),
    .seg_o (sign_seg_o)
  );

  snib_digit_glyph u_digit (
    .mag_i (mag),
    .seg_o (mag_seg_o)
  );
endmodule

// File: rtl/snib_seg_display_chk.sv
module snib_seg_display_chk (
  input logic [3:0] code_i,
  input logic [6:0] sign_seg_o,
  input logic [6:0] mag_seg_o
);
  always_comb begin
    // R3
    sign_bar_chk: assert (sign_seg_o[6] == code_i[3]);
    // R4
    sign_upper_dark_chk: assert (sign_seg_o[5:0] == 6'b0);
    // R7
    most_neg_chk: assert (code_i != 4'b1000 || mag_seg_o == 7'b1111111);
    // R8
    zero_chk: assert (code_i != 4'b0000 || (mag_seg_o == 7'b0111111 && sign_seg_o == 7'b0));
    // R1
    digit_lit_chk: assert (mag_seg_o != 7'b0);
  end
endmodule

bind snib_seg_display snib_seg_display_chk u_chk (
  .code_i     (code_i),
  .sign_seg_o (sign_seg_o),
  .mag_seg_o  (mag_seg_o)
);

// File: tb/test_snib_seg_display.sv
module test_snib_seg_display;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] code;
  logic [6:0] sign_seg, mag_seg;
  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  snib_seg_display i_snib_seg_display (
    .code_i     (code),
    .sign_seg_o (sign_seg),
    .mag_seg_o  (mag_seg)
  );

  // Reference digit shape built segment by segment (bit0 = a .. bit6 = g)
  function automatic logic [6:0] ref_shape(input int d);
    logic [6:0] s;
    s[0] = d inside {0, 2, 3, 5, 6, 7, 8};
    s[1] = d inside {0, 1, 2, 3, 4, 7, 8};
    s[2] = d inside {0, 1, 3, 4, 5, 6, 7, 8};
    s[3] = d inside {0, 2, 3, 5, 6, 8};
    s[4] = d inside {0, 2, 6, 8};
    s[5] = d inside {0, 4, 5, 6, 8};
    s[6] = d inside {2, 3, 4, 5, 6, 8};
    return s;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s code=%b actual=%b expected=%b", req, code, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c);
    @(posedge clk);
    code = c;
    @(negedge clk);
  endtask

  task automatic run_reset_state;
    drive(4'b0000);
    check("R8 sign", sign_seg, 7'b0000000);
    check("R8 mag", mag_seg, 7'b0111111);
  endtask

  task automatic run_positive;
    for (int v = 1; v <= 7; v++) begin
      drive(4'(v));
      check("R5 mag", mag_seg, ref_shape(v));
      check("R3 sign off", sign_seg, 7'b0000000);
    end
    drive(4'b0011);
    check("R5 three", mag_seg, 7'b1001111);
  endtask

  task automatic run_negative;
    for (int v = -7; v <= -1; v++) begin
      drive(4'(v));
      check("R6 mag", mag_seg, ref_shape(-v));
      check("R3 sign bar", sign_seg, 7'b1000000);
    end
  endtask

  task automatic run_most_negative;
    drive(4'b1000);
    check("R7 mag", mag_seg, 7'b1111111);
    check("R7 sign", sign_seg, 7'b1000000);
  endtask

  task automatic run_sign_sweep;
    for (int c = 0; c < 16; c++) begin
      drive(4'(c));
      check("R4 upper dark", {1'b0, sign_seg[5:0]}, 7'b0);
      check("R2 R1 value", mag_seg, ref_shape(c < 8 ? c : 16 - c));
    end
  endtask

  initial begin
    code = 4'b0000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    run_reset_state();
    run_positive();
    run_negative();
    run_most_negative();
    run_sign_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule